// File: doc/BRIEF.md
# Field-Aware Frame Buffer Scan Address Generator

This block walks a frame buffer in memory for the active display window. At the start of each field it loads the base for that field. The long field and the short field each have their own base, which lets an interlaced display start the odd field one stored line further in. On each line strobe it issues one 32-bit word fetch per cycle for a programmed number of words. At the end of the line it jumps ahead by a programmable modulo, so an interlaced field can skip every other stored line. A scan-doubling option fetches each stored line twice before it moves on.

Words come back from memory with an in-order valid. The block unpacks them into ARGB pixels on two output lanes. It supports two 16-bit formats, a packed 24-bit format and a 32-bit format. Memory arbitration and raster timing are outside this block: the strobes come from a timing generator, and the returned words come from an arbiter.

Top module: `fbscan_addr_gen`

## Requirements
- R1: While rst_n is low, fetch_req is 0 and px_valid is 2'b00.
- R2: field_start loads the starting line address. It uses base_short when field_odd is 1 and base_long when field_odd is 0. field_start also abandons any line in progress, so fetch_req is 0 in the following cycle.
- R3: A line_start during an active field, with no line in progress, is sampled at a clock edge. From the next cycle, fetch_req is high for words_m1+1 consecutive cycles, and fetch_addr starts at the current line address and rises by 1 each cycle. A line_start that arrives while a line is in progress is ignored.
- R4: After the last word of a line at address L, the next stored line starts at L + modulo. A modulo of 1 therefore means contiguous lines.
- R5: A field holds lines_m1+1 stored lines. Once they are fetched, line_start is ignored until the next field_start.
- R6: With dbl_scan = 1, each stored line is fetched twice at identical addresses. The line address advances only after the second copy, and both copies count as one stored line.
- R7: pix_fmt = 0 selects RGB555. Each word yields two pixels: px_lo from bits 15:0 and px_hi from bits 31:16. Each halfword holds R in 14:10, G in 9:5 and B in 4:0. Each component is widened to 8 bits by appending its top 3 bits. Alpha is 8'hFF.
- R8: pix_fmt = 1 selects RGB565, laid out the same way as R7 but with R in 15:11, G in 10:5 and B in 4:0. G is widened by appending its top 2 bits.
- R9: pix_fmt = 2 selects packed 24-bit colour. Bytes are taken in order from low to high address, and each word's byte 0 is in bits 7:0. Each pixel is {8'hFF, b2, b1, b0}, built from three consecutive bytes. Across each run of three words, the pixels come out as 1, 1 and 2; the second of the two pixels in the third word is on px_hi. The grouping restarts at every line_start.
- R10: pix_fmt = 3 passes each word through as one pixel on px_lo, with px_valid = 2'b01.
- R11: A word with rd_valid produces its pixels in the next cycle. A cycle without rd_valid produces px_valid = 2'b00, and px_valid is never 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_long | input | 24 | Word address of the first line, long field |
| base_short | input | 24 | Word address of the first line, short field |
| words_m1 | input | 10 | Words fetched per line, minus one |
| lines_m1 | input | 10 | Stored lines per field, minus one |
| modulo | input | 10 | Step from a line's last word to the next line's first word |
| pix_fmt | input | 2 | Pixel format: 0 RGB555, 1 RGB565, 2 packed 24-bit, 3 ARGB |
| dbl_scan | input | 1 | Fetch every stored line twice |
| field_start | input | 1 | Start-of-field strobe |
| field_odd | input | 1 | Field parity; 1 selects the short-field base |
| line_start | input | 1 | Start-of-line strobe |
| fetch_req | output | 1 | Word fetch request |
| fetch_addr | output | 24 | Word address of the fetch |
| rd_valid | input | 1 | Returned word valid, in request order |
| rd_data | input | 32 | Returned word |
| px_valid | output | 2 | Lane valid: bit 0 for px_lo, bit 1 for px_hi |
| px_lo | output | 32 | First pixel, ARGB |
| px_hi | output | 32 | Second pixel, ARGB |

## Verification
The main function is tried with four field setups, and each one isolates a different mechanism.

- A progressive RGB565 field with modulo 1 shows that lines are contiguous and that the lines-per-field limit holds.
- An interlaced RGB555 field on the short base, with the modulo set to one line plus one, separates the two bases and shows the skip of one stored line. It also pokes line_start in mid-line to show that the poke is ignored.
- A scan-doubled field in packed 24-bit mode shows that each line is repeated at the same addresses before the address moves on, and that the 1-1-2 byte grouping restarts on every line.
- A final ARGB field with an odd modulo shows single-pixel words and a non-trivial step between lines.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;

  localparam int PIX_W = 32;

  typedef enum logic [1:0] {
    FMT_RGB555  = 2'd0,
    FMT_RGB565  = 2'd1,
    FMT_PACK24  = 2'd2,
    FMT_ARGB    = 2'd3
  } pix_fmt_e;

  function automatic logic [7:0] widen5(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] c);
    return {c, c[5:4]};
  endfunction

endpackage

// File: rtl/fbscan_walker.sv
module fbscan_walker #(
  parameter int AW = 24,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          field_start,
  input  logic          field_odd,
  input  logic          line_start,
  input  logic [AW-1:0] base_long,
  input  logic [AW-1:0] base_short,
  input  logic [CW-1:0] words_m1,
  input  logic [CW-1:0] lines_m1,
  input  logic [CW-1:0] modulo,
  input  logic          dbl_scan,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr
);

  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  logic          active_q, active_d;
  logic          busy_q, busy_d;
  logic          rep_q, rep_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] cur_q, cur_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic [CW-1:0] lidx_q, lidx_d;
  logic          step_en;
  logic          last_word;

  assign last_word = (wcnt_q == words_m1);
  assign step_en   = field_start | busy_q | (line_start & active_q);

  always_comb begin
    active_d = active_q;
    busy_d   = busy_q;
    rep_d    = rep_q;
    ptr_d    = ptr_q;
    cur_d    = cur_q;
    wcnt_d   = wcnt_q;
    lidx_d   = lidx_q;
    if (field_start) begin
      active_d = 1'b1;
      busy_d   = 1'b0;
      rep_d    = 1'b0;
      lidx_d   = '0;
      ptr_d    = field_odd ? base_short : base_long;
    end else if (busy_q) begin
      if (last_word) begin
        busy_d = 1'b0;
        if (dbl_scan && !rep_q) begin
          rep_d = 1'b1;
        end else begin
          rep_d = 1'b0;
          ptr_d = cur_q + AW'(modulo);
          if (lidx_q == lines_m1) active_d = 1'b0;
          else                    lidx_d   = lidx_q + C_ONE;
        end
      end else begin
        cur_d  = cur_q + A_ONE;
        wcnt_d = wcnt_q + C_ONE;
      end
    end else if (line_start && active_q) begin
      busy_d = 1'b1;
      cur_d  = ptr_q;
      wcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      busy_q   <= 1'b0;
      rep_q    <= 1'b0;
      ptr_q    <= '0;
      cur_q    <= '0;
      wcnt_q   <= '0;
      lidx_q   <= '0;
    end else if (step_en) begin
      active_q <= active_d;
      busy_q   <= busy_d;
      rep_q    <= rep_d;
      ptr_q    <= ptr_d;
      cur_q    <= cur_d;
      wcnt_q   <= wcnt_d;
      lidx_q   <= lidx_d;
    end
  end

  assign fetch_req  = busy_q;
  assign fetch_addr = cur_q;

endmodule

// File: rtl/fbscan_unpack.sv
module fbscan_unpack
  import fbscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             realign,
  input  logic [1:0]       fmt,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic [1:0]       px_valid,
  output logic [PIX_W-1:0] px_lo,
  output logic [PIX_W-1:0] px_hi
);

  logic [PIX_W-1:0] half_px [2];
  logic [1:0]       phase_q, phase_d, phase_eff;
  logic [15:0]      hold_q, hold_d;
  logic [1:0]       vld_q, vld_d;
  logic [PIX_W-1:0] lo_q, lo_d, hi_q, hi_d;
  pix_fmt_e         fmt_e;

  assign fmt_e = pix_fmt_e'(fmt);

  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [15:0] h;
    assign h = rd_data[16*g +: 16];
    always_comb begin
      if (fmt_e == FMT_RGB565)
        half_px[g] = {8'hFF, widen5(h[15:11]), widen6(h[10:5]), widen5(h[4:0])};
      else
        half_px[g] = {8'hFF, widen5(h[14:10]), widen5(h[9:5]), widen5(h[4:0])};
    end
  end

  assign phase_eff = realign ? 2'd0 : phase_q;

  always_comb begin
    phase_d = phase_eff;
    hold_d  = hold_q;
    vld_d   = 2'b00;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (rd_valid) begin
      unique case (fmt_e)
        FMT_RGB555, FMT_RGB565: begin
          vld_d = 2'b11;
          lo_d  = half_px[0];
          hi_d  = half_px[1];
        end
        FMT_ARGB: begin
          vld_d = 2'b01;
          lo_d  = rd_data;
        end
        default: begin
          unique case (phase_eff)
            2'd0: begin
              vld_d   = 2'b01;
              lo_d    = {8'hFF, rd_data[23:0]};
              hold_d  = {8'h00, rd_data[31:24]};
              phase_d = 2'd1;
            end
            2'd1: begin
              vld_d   = 2'b01;
              lo_d    = {8'hFF, rd_data[15:0], hold_q[7:0]};
              hold_d  = rd_data[31:16];
              phase_d = 2'd2;
            end
            default: begin
              vld_d   = 2'b11;
              lo_d    = {8'hFF, rd_data[7:0], hold_q};
              hi_d    = {8'hFF, rd_data[31:8]};
              phase_d = 2'd0;
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      hold_q  <= '0;
      vld_q   <= 2'b00;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      phase_q <= phase_d;
      hold_q  <= hold_d;
      vld_q   <= vld_d;
      if (rd_valid) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
    end
  end

  assign px_valid = vld_q;
  assign px_lo    = lo_q;
  assign px_hi    = hi_q;

endmodule

// File: rtl/fbscan_addr_gen.sv
module fbscan_addr_gen
  import fbscan_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    base_long,
  input  logic [AW-1:0]    base_short,
  input  logic [CW-1:0]    words_m1,
  input  logic [CW-1:0]    lines_m1,
  input  logic [CW-1:0]    modulo,
  input  logic [1:0]       pix_fmt,
  input  logic             dbl_scan,
  input  logic             field_start,
  input  logic             field_odd,
  input  logic             line_start,
  output logic             fetch_req,
  output logic [AW-1:0]    fetch_addr,
  input  logic             rd_valid,
  input  logic [31:0]      rd_data,
  output logic [1:0]       px_valid,
  output logic [PIX_W-1:0] px_lo,
  output logic [PIX_W-1:0] px_hi
);

  logic realign;
  assign realign = line_start | field_start;

  fbscan_walker #(.AW(AW), .CW(CW)) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .field_odd   (field_odd),
    .line_start  (line_start),
    .base_long   (base_long),
    .base_short  (base_short),
    .words_m1    (words_m1),
    .lines_m1    (lines_m1),
    .modulo      (modulo),
    .dbl_scan    (dbl_scan),
    .fetch_req   (fetch_req),
    .fetch_addr  (fetch_addr)
  );

  fbscan_unpack u_unpack (
    .clk      (clk),
    .rst_n    (rst_n),
    .realign  (realign),
    .fmt      (pix_fmt),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .px_valid (px_valid),
    .px_lo    (px_lo),
    .px_hi    (px_hi)
  );

endmodule

// File: rtl/fbscan_checks.sv
module fbscan_checks #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          field_start,
  input logic          line_start,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_addr,
  input logic          rd_valid,
  input logic [1:0]    pix_fmt,
  input logic [1:0]    px_valid
);

  // R3: addresses within a line are consecutive words
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && $past(fetch_req)) |-> (fetch_addr == $past(fetch_addr) + AW'(1)));

  // R3: a line only begins after a sampled line strobe
  a_r3_start_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> $past(line_start));

  // R2: a field strobe cancels any line in flight
  a_r2_field_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> !fetch_req);

  // R11: no returned word, no pixels
  a_r11_no_data_no_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (px_valid == 2'b00));

  // R11: upper lane never valid alone
  a_r11_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid != 2'b10);

  // R7 / R8: every 16-bit word yields two pixels
  a_r7_two_pixels_16b: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (pix_fmt == 2'd0 || pix_fmt == 2'd1)) |=> (px_valid == 2'b11));

endmodule

bind fbscan_addr_gen fbscan_checks #(.AW(AW)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .field_start (field_start),
  .line_start  (line_start),
  .fetch_req   (fetch_req),
  .fetch_addr  (fetch_addr),
  .rd_valid    (rd_valid),
  .pix_fmt     (pix_fmt),
  .px_valid    (px_valid)
);

// File: tb/fbscan_addr_gen_test.sv
module fbscan_addr_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] base_long = '0, base_short = '0;
  logic [9:0]  words_m1 = '0, lines_m1 = '0, modulo = '0;
  logic [1:0]  pix_fmt = '0;
  logic        dbl_scan = 1'b0, field_start = 1'b0, field_odd = 1'b0, line_start = 1'b0;
  logic        fetch_req;
  logic [23:0] fetch_addr;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic [1:0]  px_valid;
  logic [31:0] px_lo, px_hi;

  int n_chk = 0, n_bad = 0;

  logic [23:0] exp_a[$];  string tag_a[$];
  logic [31:0] exp_p[$];  string tag_p[$];

  logic [23:0] m_ptr;
  int          m_idx;
  bit          m_rep, m_act, m_first;

  always #4 clk = ~clk;

  fbscan_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .base_long(base_long), .base_short(base_short),
    .words_m1(words_m1), .lines_m1(lines_m1), .modulo(modulo), .pix_fmt(pix_fmt),
    .dbl_scan(dbl_scan), .field_start(field_start), .field_odd(field_odd),
    .line_start(line_start), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .px_valid(px_valid),
    .px_lo(px_lo), .px_hi(px_hi)
  );

  function automatic logic [31:0] memf(input logic [23:0] a);
    logic [31:0] x;
    x = {8'h00, a} * 32'h9E3779B1;
    return x ^ {a[7:0], 24'h5A3C96};
  endfunction

  // memory returns one cycle after the request
  always @(posedge clk) begin
    rd_valid <= fetch_req;
    rd_data  <= memf(fetch_addr);
  end

  function automatic logic [31:0] pix16(input logic [15:0] h, input bit g6);
    logic [4:0] r, b; logic [7:0] g8;
    b = h[4:0];
    if (g6) begin r = h[15:11]; g8 = {h[10:5], h[10:9]}; end
    else    begin r = h[14:10]; g8 = {h[9:5], h[9:7]}; end
    return {8'hFF, r, r[4:2], g8, b, b[4:2]};
  endfunction

  task automatic fail(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_bad++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
  endtask

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req) begin
        n_chk++;
        if (exp_a.size() == 0) fail("R3", "unexpected fetch", {8'h0, fetch_addr}, 32'h0);
        else begin
          logic [23:0] e; string t;
          e = exp_a.pop_front(); t = tag_a.pop_front();
          if (fetch_addr !== e) fail(t, "fetch_addr", {8'h0, fetch_addr}, {8'h0, e});
        end
      end
      for (int l = 0; l < 2; l++) begin
        if (px_valid[l]) begin
          logic [31:0] got;
          got = (l == 0) ? px_lo : px_hi;
          n_chk++;
          if (exp_p.size() == 0) fail("R11", "unexpected pixel", got, 32'h0);
          else begin
            logic [31:0] e; string t;
            e = exp_p.pop_front(); t = tag_p.pop_front();
            if (got !== e) fail(t, (l == 0) ? "px_lo" : "px_hi", got, e);
          end
        end
      end
    end
  end

  // driver-side model of one accepted line
  task automatic model_line();
    logic [23:0] a; logic [31:0] w; logic [15:0] hold; int ph;
    string pt;
    if (!m_act) return;
    ph = 0; hold = '0;
    pt = (pix_fmt == 2'd0) ? "R7" : (pix_fmt == 2'd1) ? "R8" : (pix_fmt == 2'd2) ? "R9" : "R10";
    for (int k = 0; k <= int'(words_m1); k++) begin
      a = m_ptr + 24'(k);
      exp_a.push_back(a);
      if (k != 0) tag_a.push_back("R3");
      else if (m_first) tag_a.push_back("R2");
      else if (dbl_scan) tag_a.push_back("R6");
      else tag_a.push_back("R4");
      w = memf(a);
      case (pix_fmt)
        2'd0, 2'd1: begin
          exp_p.push_back(pix16(w[15:0], pix_fmt[0]));  tag_p.push_back(pt);
          exp_p.push_back(pix16(w[31:16], pix_fmt[0])); tag_p.push_back(pt);
        end
        2'd3: begin exp_p.push_back(w); tag_p.push_back(pt); end
        default: begin
          if (ph == 0) begin
            exp_p.push_back({8'hFF, w[23:0]}); hold = {8'h0, w[31:24]}; ph = 1;
            tag_p.push_back(pt);
          end else if (ph == 1) begin
            exp_p.push_back({8'hFF, w[15:0], hold[7:0]}); hold = w[31:16]; ph = 2;
            tag_p.push_back(pt);
          end else begin
            exp_p.push_back({8'hFF, w[7:0], hold}); tag_p.push_back(pt);
            exp_p.push_back({8'hFF, w[31:8]});      tag_p.push_back(pt);
            ph = 0;
          end
        end
      endcase
    end
    m_first = 1'b0;
    a = m_ptr + 24'(words_m1);
    if (dbl_scan && !m_rep) m_rep = 1'b1;
    else begin
      m_rep = 1'b0;
      m_ptr = a + 24'(modulo);
      if (m_idx == int'(lines_m1)) m_act = 1'b0;
      else m_idx++;
    end
  endtask

  task automatic start_field(input bit odd);
    @(posedge clk); #1 field_start = 1'b1; field_odd = odd;
    @(posedge clk); #1 field_start = 1'b0;
    m_act = 1'b1; m_idx = 0; m_rep = 1'b0; m_first = 1'b1;
    m_ptr = odd ? base_short : base_long;
  endtask

  task automatic do_line(input bit poke);
    @(posedge clk); #1 line_start = 1'b1;
    @(posedge clk); #1 line_start = 1'b0;
    model_line();
    if (poke) begin  // second strobe while busy must be ignored (R3)
      @(posedge clk); #1 line_start = 1'b1;
      @(posedge clk); #1 line_start = 1'b0;
    end
    repeat (int'(words_m1) + 6) @(posedge clk);
  endtask

  task automatic chk_idle(input string tag, input int cyc);
    bit bad = 1'b0;
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (fetch_req || px_valid != 2'b00) bad = 1'b1;
    end
    n_chk++;
    if (bad) fail(tag, "idle outputs active", {30'h0, px_valid}, 32'h0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_act = 1'b0; m_idx = 0; m_rep = 1'b0; m_first = 1'b0; m_ptr = '0;
    // R1: outputs quiet during reset
    repeat (3) @(negedge clk);
    n_chk++;
    if (fetch_req !== 1'b0 || px_valid !== 2'b00)
      fail("R1", "reset outputs", {30'h0, px_valid}, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;

    // progressive RGB565, contiguous lines (R2 R3 R4 R5 R8)
    base_long = 24'h000100; base_short = 24'h000104;
    words_m1 = 10'd3; lines_m1 = 10'd2; modulo = 10'd1; pix_fmt = 2'd1; dbl_scan = 1'b0;
    start_field(1'b0);
    for (int i = 0; i < 3; i++) do_line(1'b0);
    do_line(1'b0);
    chk_idle("R5", 6);

    // interlaced RGB555 on the short base, mid-line pokes (R2 R3 R4 R7)
    modulo = 10'd5; pix_fmt = 2'd0;
    start_field(1'b1);
    for (int i = 0; i < 3; i++) do_line(1'b1);
    chk_idle("R11", 4);

    // scan doubled packed 24-bit (R6 R9 R5)
    base_long = 24'h0A0000; words_m1 = 10'd5; lines_m1 = 10'd1; modulo = 10'd1;
    pix_fmt = 2'd2; dbl_scan = 1'b1;
    start_field(1'b0);
    for (int i = 0; i < 4; i++) do_line(1'b0);
    do_line(1'b0);
    chk_idle("R5", 6);

    // ARGB with odd modulo (R10 R4), field restarted mid-field (R2)
    base_long = 24'hFFFFF0; words_m1 = 10'd2; lines_m1 = 10'd3; modulo = 10'd7;
    pix_fmt = 2'd3; dbl_scan = 1'b0;
    start_field(1'b0);
    do_line(1'b0);
    start_field(1'b0);
    for (int i = 0; i < 4; i++) do_line(1'b0);
    chk_idle("R5", 4);

    repeat (4) @(negedge clk);
    n_chk++;
    if (exp_a.size() != 0) fail("R3", "missing fetches", exp_a.size(), 0);
    n_chk++;
    if (exp_p.size() != 0) fail("R11", "missing pixels", exp_p.size(), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule